// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block turns a scaling request into the set-up numbers a video scaling engine needs. A request gives a mask of planes that ask for scaling, plus the source width and height and the destination width and height, all as plain integers. The block checks that exactly one plane is named and that no dimension is zero. For a valid request it then computes, for each axis, a fixed-point phase increment, a rounded initial phase and an unsigned 16.16 upscale factor. It also raises an enable for a detail-enhancer stage when either axis enlarges by a factor of two or more.

A one-cycle `start` launches the work. Invalid and empty requests finish at once. Valid requests use one restoring divider that produces one quotient bit per clock, so they finish after a fixed number of cycles. All results stay on the outputs until the next accepted start.

Top module: `scaler_phase_calc`

## Requirements
- R1: A start whose plane mask has more than one bit set gives error=1 and scaleEn=0, with all numeric results zero. done is high in the cycle right after the edge that samples start, and busy never rises.
- R2: A start with an all-zero plane mask gives error=0 and scaleEn=0, with all results zero and enhEn=0. done is high in the cycle right after the sampling edge.
- R3: A start with exactly one mask bit set and all four dimensions non-zero gives scaleEn=1 and error=0. done is high for exactly one cycle, 4*(2*DIM_W+2) clock edges (136 by default) after the edge that samples start.
- R4: The phase increment per axis is (source << 16) / destination, truncated to an integer and 32 bits wide. The horizontal axis uses the widths and the vertical axis uses the heights.
- R5: The initial phase per axis is ((source << 4) / destination + 1) / 2, using integer division at each step.
- R6: The upscale factor per axis is (destination << 16) / source, an unsigned 16.16 value.
- R7: enhEn is 1 exactly when the integer part (bits 31:16) of the horizontal or the vertical upscale factor is 2 or more.
- R8: A start with one mask bit set but any dimension equal to zero gives error=1, scaleEn=0 and all results zero. done is high in the cycle right after the sampling edge.
- R9: From done until the next accepted start, all results and flags stay constant, even when the dimension and mask inputs change.
- R10: busy is high from the edge that accepts a valid request until the cycle before done. A start asserted while busy is ignored: the results and the done timing are those of the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| planeMask | input | NPLANES | One bit per plane asking for scaling |
| srcW | input | DIM_W | Source width in pixels |
| srcH | input | DIM_W | Source height in lines |
| dstW | input | DIM_W | Destination width |
| dstH | input | DIM_W | Destination height |
| busy | output | 1 | Divisions in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Request rejected |
| scaleEn | output | 1 | Valid scaling set-up produced |
| enhEn | output | 1 | Detail enhancer enable |
| hInitPhase | output | 2*DIM_W-12 | Horizontal initial phase |
| vInitPhase | output | 2*DIM_W-12 | Vertical initial phase |
| hDeltaPhase | output | 2*DIM_W | Horizontal phase increment |
| vDeltaPhase | output | 2*DIM_W | Vertical phase increment |
| hUpFactor | output | 2*DIM_W | Horizontal upscale factor, U16.16 |
| vUpFactor | output | 2*DIM_W | Vertical upscale factor, U16.16 |

## Verification
A wrong step counter or a wrong operation counter in the control shows up first as a shift in the done cycle, or as a busy signal that ends early. The cycle-by-cycle model catches this on the exact clock where it happens. A wrong divider bit or a mixed-up operand shows up only at done, as one wrong quotient. Odd ratios, one-to-one ratios, extreme dimensions and just-below-2x ratios are chosen so that each wrong operand or a truncation slip changes a visible value. A start that corrupts the state while the block is busy would show up at done as results or timing that differ from the first request.

// File: rtl/scaler_phase_pkg.sv
package scaler_phase_pkg;

  localparam int NUM_OPS = 4;
  localparam int OP_W = 2;

  // operation order: 0 h increment, 1 v increment, 2 h upscale, 3 v upscale
  typedef struct packed {
    logic            latch;
    logic            load;
    logic            step;
    logic            capture;
    logic [OP_W-1:0] op;
  } sclStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIV,
    ST_STORE,
    ST_FIN
  } sclState_t;

endpackage

// File: rtl/scaler_phase_ctrl.sv
module scaler_phase_ctrl
  import scaler_phase_pkg::*;
#(
  parameter int NPLANES = 4,
  parameter int DIM_W   = 16,
  parameter int QUO_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NPLANES-1:0] planeMask,
  input  logic [DIM_W-1:0]   srcW,
  input  logic [DIM_W-1:0]   srcH,
  input  logic [DIM_W-1:0]   dstW,
  input  logic [DIM_W-1:0]   dstH,
  output sclStrobe_t         strobe,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic               scaleEn
);

  localparam int STEP_W = $clog2(QUO_W + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(QUO_W - 1);
  localparam logic [OP_W-1:0]   LAST_OP   = OP_W'(NUM_OPS - 1);

  sclState_t         state, stateNext;
  logic [STEP_W-1:0] stepCnt;
  logic [OP_W-1:0]   opCnt;
  logic              accept, maskMulti, maskEmpty, dimZero, reject;

  always_comb begin
    accept    = (state == ST_IDLE) && start;
    maskMulti = |(planeMask & (planeMask - NPLANES'(1)));
    maskEmpty = (planeMask == '0);
    dimZero   = (srcW == '0) || (srcH == '0) || (dstW == '0) || (dstH == '0);
    reject    = maskMulti || maskEmpty || dimZero;

    strobe.latch   = accept;
    strobe.load    = (state == ST_LOAD);
    strobe.step    = (state == ST_DIV);
    strobe.capture = (state == ST_STORE);
    strobe.op      = opCnt;

    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = reject ? ST_FIN : ST_LOAD;
      ST_LOAD:  stateNext = ST_DIV;
      ST_DIV:   if (stepCnt == LAST_STEP) stateNext = ST_STORE;
      ST_STORE: stateNext = (opCnt == LAST_OP) ? ST_FIN : ST_LOAD;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      opCnt   <= '0;
      error   <= 1'b0;
      scaleEn <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        opCnt   <= '0;
        error   <= maskMulti || (!maskEmpty && dimZero);
        scaleEn <= !reject;
      end
      if (state == ST_LOAD) stepCnt <= '0;
      else if (state == ST_DIV) stepCnt <= stepCnt + STEP_W'(1);
      if (state == ST_STORE && opCnt != LAST_OP) opCnt <= opCnt + OP_W'(1);
    end
  end

  assign busy = (state == ST_LOAD) || (state == ST_DIV) || (state == ST_STORE);
  assign done = (state == ST_FIN);

  AST_MULTI_MASK_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && $countones(planeMask) > 1) |=> (error && !scaleEn && done)); // R1
  AST_EMPTY_MASK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && planeMask == '0) |=> (!error && !scaleEn && done)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_ZERO_DIM_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && $onehot0(planeMask) && planeMask != '0 &&
     (srcW == '0 || dstH == '0 || srcH == '0 || dstW == '0)) |=> (error && done)); // R8
  AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(error) && $stable(scaleEn))); // R10

endmodule

// File: rtl/scaler_phase_datapath.sv
module scaler_phase_datapath
  import scaler_phase_pkg::*;
#(
  parameter int DIM_W    = 16,
  parameter int PH_BITS  = 4,
  parameter int PH_EXTRA = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  sclStrobe_t                   strobe,
  input  logic [DIM_W-1:0]             srcW,
  input  logic [DIM_W-1:0]             srcH,
  input  logic [DIM_W-1:0]             dstW,
  input  logic [DIM_W-1:0]             dstH,
  output logic                         enhEn,
  output logic [2*DIM_W-PH_EXTRA-1:0]  hInitPhase,
  output logic [2*DIM_W-PH_EXTRA-1:0]  vInitPhase,
  output logic [2*DIM_W-1:0]           hDeltaPhase,
  output logic [2*DIM_W-1:0]           vDeltaPhase,
  output logic [2*DIM_W-1:0]           hUpFactor,
  output logic [2*DIM_W-1:0]           vUpFactor
);

  localparam int FRAC_W = PH_BITS + PH_EXTRA;
  localparam int QUO_W  = DIM_W + FRAC_W;
  localparam int INIT_W = QUO_W - PH_EXTRA;

  logic [DIM_W-1:0] srcWq, srcHq, dstWq, dstHq, divisorQ;
  logic [DIM_W:0]   remQ;
  logic [QUO_W-1:0] quoQ;
  logic             divActive;
  logic [QUO_W-1:0] resQ [NUM_OPS];

  logic [QUO_W-1:0] loadNum;
  logic [DIM_W-1:0] loadDen;
  logic [DIM_W:0]   shifted;
  logic [DIM_W+1:0] diff;

  always_comb begin
    unique case (strobe.op)
      2'd0:    begin loadNum = {srcWq, {FRAC_W{1'b0}}}; loadDen = dstWq; end
      2'd1:    begin loadNum = {srcHq, {FRAC_W{1'b0}}}; loadDen = dstHq; end
      2'd2:    begin loadNum = {dstWq, {FRAC_W{1'b0}}}; loadDen = srcWq; end
      default: begin loadNum = {dstHq, {FRAC_W{1'b0}}}; loadDen = srcHq; end
    endcase
    shifted = {remQ[DIM_W-1:0], quoQ[QUO_W-1]};
    diff    = {1'b0, shifted} - {2'b00, divisorQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcWq <= '0; srcHq <= '0; dstWq <= '0; dstHq <= '0;
      divisorQ <= '0; remQ <= '0; quoQ <= '0; divActive <= 1'b0;
      for (int i = 0; i < NUM_OPS; i++) resQ[i] <= '0;
    end else begin
      if (strobe.latch) begin
        srcWq <= srcW; srcHq <= srcH; dstWq <= dstW; dstHq <= dstH;
        for (int i = 0; i < NUM_OPS; i++) resQ[i] <= '0;
      end
      if (strobe.load) begin
        quoQ      <= loadNum;
        divisorQ  <= loadDen;
        remQ      <= '0;
        divActive <= 1'b1;
      end else if (strobe.step) begin
        if (!diff[DIM_W+1]) begin
          remQ <= diff[DIM_W:0];
          quoQ <= {quoQ[QUO_W-2:0], 1'b1};
        end else begin
          remQ <= shifted;
          quoQ <= {quoQ[QUO_W-2:0], 1'b0};
        end
      end
      if (strobe.capture) begin
        resQ[strobe.op] <= quoQ;
        divActive       <= 1'b0;
      end
    end
  end

  function automatic logic [INIT_W-1:0] initFromDelta(input logic [QUO_W-1:0] delta);
    logic [INIT_W:0] t;
    t = {1'b0, delta[QUO_W-1:PH_EXTRA]} + (INIT_W+1)'(1);
    return t[INIT_W:1];
  endfunction

  assign hDeltaPhase = resQ[0];
  assign vDeltaPhase = resQ[1];
  assign hUpFactor   = resQ[2];
  assign vUpFactor   = resQ[3];
  assign hInitPhase  = initFromDelta(resQ[0]);
  assign vInitPhase  = initFromDelta(resQ[1]);
  assign enhEn = (resQ[2][QUO_W-1:FRAC_W] >= DIM_W'(2)) ||
                 (resQ[3][QUO_W-1:FRAC_W] >= DIM_W'(2));

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    divActive |-> (remQ < {1'b0, divisorQ})); // R4
  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.latch && !strobe.capture) |=> $stable({resQ[0], resQ[1], resQ[2], resQ[3]})); // R9

endmodule

// File: rtl/scaler_phase_calc.sv
module scaler_phase_calc
  import scaler_phase_pkg::*;
#(
  parameter int NPLANES = 4,
  parameter int DIM_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NPLANES-1:0] planeMask,
  input  logic [DIM_W-1:0]   srcW,
  input  logic [DIM_W-1:0]   srcH,
  input  logic [DIM_W-1:0]   dstW,
  input  logic [DIM_W-1:0]   dstH,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic               scaleEn,
  output logic               enhEn,
  output logic [2*DIM_W-13:0] hInitPhase,
  output logic [2*DIM_W-13:0] vInitPhase,
  output logic [2*DIM_W-1:0] hDeltaPhase,
  output logic [2*DIM_W-1:0] vDeltaPhase,
  output logic [2*DIM_W-1:0] hUpFactor,
  output logic [2*DIM_W-1:0] vUpFactor
);

  localparam int PH_BITS  = 4;
  localparam int PH_EXTRA = 12;
  localparam int QUO_W    = DIM_W + PH_BITS + PH_EXTRA;

  sclStrobe_t strobe;

  scaler_phase_ctrl #(
    .NPLANES(NPLANES), .DIM_W(DIM_W), .QUO_W(QUO_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .planeMask(planeMask),
    .srcW(srcW), .srcH(srcH), .dstW(dstW), .dstH(dstH),
    .strobe(strobe), .busy(busy), .done(done), .error(error), .scaleEn(scaleEn)
  );

  scaler_phase_datapath #(
    .DIM_W(DIM_W), .PH_BITS(PH_BITS), .PH_EXTRA(PH_EXTRA)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcW(srcW), .srcH(srcH), .dstW(dstW), .dstH(dstH),
    .enhEn(enhEn), .hInitPhase(hInitPhase), .vInitPhase(vInitPhase),
    .hDeltaPhase(hDeltaPhase), .vDeltaPhase(vDeltaPhase),
    .hUpFactor(hUpFactor), .vUpFactor(vUpFactor)
  );

endmodule

// File: tb/tb_scaler_phase_calc.sv
module tb_scaler_phase_calc;

  localparam int NPLANES = 4;
  localparam int DIM_W   = 16;
  localparam int LAT     = 4 * (2 * DIM_W + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NPLANES-1:0] planeMask = '0;
  logic [DIM_W-1:0] srcW = '0, srcH = '0, dstW = '0, dstH = '0;
  logic busy, done, error, scaleEn, enhEn;
  logic [2*DIM_W-13:0] hInitPhase, vInitPhase;
  logic [2*DIM_W-1:0] hDeltaPhase, vDeltaPhase, hUpFactor, vUpFactor;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  scaler_phase_calc #(.NPLANES(NPLANES), .DIM_W(DIM_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .planeMask(planeMask),
    .srcW(srcW), .srcH(srcH), .dstW(dstW), .dstH(dstH),
    .busy(busy), .done(done), .error(error), .scaleEn(scaleEn), .enhEn(enhEn),
    .hInitPhase(hInitPhase), .vInitPhase(vInitPhase),
    .hDeltaPhase(hDeltaPhase), .vDeltaPhase(vDeltaPhase),
    .hUpFactor(hUpFactor), .vUpFactor(vUpFactor)
  );

  // reference model state
  longint eHD, eVD, eHI, eVI, eHU, eVU;
  bit eErr, eScale, eEnh;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelSet(input bit err, input bit scale,
                          input longint sw, input longint sh, input longint dw, input longint dh);
    eErr = err; eScale = scale;
    if (scale) begin
      eHD = (sw << 16) / dw;  eVD = (sh << 16) / dh;
      eHI = ((sw << 4) / dw + 1) / 2;  eVI = ((sh << 4) / dh + 1) / 2;
      eHU = (dw << 16) / sw;  eVU = (dh << 16) / sh;
    end else begin
      eHD = 0; eVD = 0; eHI = 0; eVI = 0; eHU = 0; eVU = 0;
    end
    eEnh = ((eHU >> 16) >= 2) || ((eVU >> 16) >= 2);
  endtask

  task automatic compareAll(input string req);
    chk(error == eErr, req, "error", longint'(error), longint'(eErr));
    chk(scaleEn == eScale, req, "scaleEn", longint'(scaleEn), longint'(eScale));
    chk(hDeltaPhase == eHD && vDeltaPhase == eVD, "R4", {req, " delta h"},
        longint'(hDeltaPhase), eHD);
    chk(vDeltaPhase == eVD, "R4", {req, " delta v"}, longint'(vDeltaPhase), eVD);
    chk(hInitPhase == eHI, "R5", {req, " init h"}, longint'(hInitPhase), eHI);
    chk(vInitPhase == eVI, "R5", {req, " init v"}, longint'(vInitPhase), eVI);
    chk(hUpFactor == eHU, "R6", {req, " up h"}, longint'(hUpFactor), eHU);
    chk(vUpFactor == eVU, "R6", {req, " up v"}, longint'(vUpFactor), eVU);
    chk(enhEn == eEnh, "R7", {req, " enhEn"}, longint'(enhEn), longint'(eEnh));
  endtask

  // after done: hold for a few idle clocks while inputs wander (R9)
  task automatic holdPhase();
    bit ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      srcW = DIM_W'(k * 37 + 3); dstH = DIM_W'(k + 9); planeMask = NPLANES'(k);
      if (done || busy || error != eErr || scaleEn != eScale || hDeltaPhase != eHD ||
          vDeltaPhase != eVD || hUpFactor != eHU || vUpFactor != eVU ||
          hInitPhase != eHI || vInitPhase != eVI || enhEn != eEnh) ok = 1'b0;
    end
    chk(ok, "R9", "results held after done", longint'(ok), 1);
  endtask

  task automatic runEarly(input logic [NPLANES-1:0] m, input int sw, input int sh,
                          input int dw, input int dh, input bit expErr, input string req);
    @(negedge clk);
    planeMask = m; srcW = DIM_W'(sw); srcH = DIM_W'(sh); dstW = DIM_W'(dw); dstH = DIM_W'(dh);
    start = 1'b1;
    modelSet(expErr, 1'b0, sw, sh, dw, dh);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, req, "done next cycle without busy",
        longint'({busy, done}), 1);
    compareAll(req);
    holdPhase();
  endtask

  task automatic runScaled(input logic [NPLANES-1:0] m, input int sw, input int sh,
                           input int dw, input int dh, input bit poke, input string tag);
    bit busyOk = 1'b1;
    int doneAt = -1;
    @(negedge clk);
    planeMask = m; srcW = DIM_W'(sw); srcH = DIM_W'(sh); dstW = DIM_W'(dw); dstH = DIM_W'(dh);
    start = 1'b1;
    modelSet(1'b0, 1'b1, sw, sh, dw, dh);
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < LAT; j++) begin
      if (!busy || done) busyOk = 1'b0;
      if (done && doneAt < 0) doneAt = j;
      if (poke && j == 10) begin
        start = 1'b1; planeMask = 4'b0011; srcW = 16'd5; dstW = 16'd0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(busyOk, "R10", {tag, " busy window"}, longint'(busyOk), 1);
    chk(done && !busy, "R3", {tag, " done at latency"}, longint'({busy, done}), 1);
    chk(doneAt < 0, "R3", {tag, " no early done"}, longint'(doneAt), -1);
    compareAll({"R3 ", tag});
    holdPhase();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    modelSet(1'b0, 1'b0, 1, 1, 1, 1);
    chk(!busy && !done, "R3", "reset idle", longint'({busy, done}), 0);
    compareAll("R2 reset");

    // exact 2x upscale, enhancer on both axes
    runScaled(4'b0001, 1920, 1080, 3840, 2160, 1'b0, "2x");
    // downscale, enhancer off
    runScaled(4'b0100, 640, 480, 320, 240, 1'b0, "down");
    // odd ratios
    runScaled(4'b1000, 1000, 7, 1333, 5, 1'b0, "odd");
    // one-to-one: integer part 1, no enhancer (R7 boundary)
    runScaled(4'b0010, 800, 600, 800, 600, 1'b0, "unity R7");
    // just below 2x horizontally, exactly 2x vertically only (R7)
    runScaled(4'b0001, 100, 50, 199, 100, 1'b0, "vert-only R7");
    runScaled(4'b0001, 100, 50, 199, 99, 1'b0, "below2x R7");
    // extremes of dimension range
    runScaled(4'b0100, 65535, 1, 1, 65535, 1'b0, "extreme");
    // start during busy is ignored (R10)
    runScaled(4'b1000, 300, 200, 450, 500, 1'b1, "poke R10");

    // rejections and empty mask
    runEarly(4'b0110, 100, 100, 200, 200, 1'b1, "R1");
    runEarly(4'b1111, 100, 100, 200, 200, 1'b1, "R1");
    runEarly(4'b0000, 100, 100, 200, 200, 1'b0, "R2");
    runEarly(4'b0010, 100, 100, 200, 0, 1'b1, "R8");
    runEarly(4'b0010, 0, 100, 200, 100, 1'b1, "R8");
    // a valid request after rejections still works
    runScaled(4'b0010, 720, 576, 1920, 1080, 1'b0, "after-reject");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule